// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional buses, A and B, in byte-wide lanes. Each lane holds two store registers: one captures the A bus for the A-to-B direction, and one captures the B bus for the B-to-A direction. A capture happens on the rising edge of that direction's capture strobe. For each direction a select input chooses between the live bus value and the stored byte as the source for the opposite bus. Each direction also has a drive enable, and the two enables have opposite polarity. The buses are modelled as separate input, output and drive-enable signals, so no tristate cells are needed. The pad or bus fabric merges them outside the block.

Everything runs on one system clock. The capture strobes are ordinary synchronous inputs, and the block detects their rising edges itself. Each output byte and each drive enable is registered, so the block responds one clock after the inputs it samples. With both directions live and both enables on, the two registered paths form a loop, and each bus keeps its last value after the external drivers let go. The default build has two independent lanes, which gives a 16-bit device.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_n is low at a clock edge, every drive enable output goes to 0, every data output goes to 0 and both store registers of every lane clear to 0. The drive enables follow the control inputs sampled at the first clock edge after release.
- R2: At a clock edge where a_cap_stb of a lane is 1 and was 0 at the previous edge, the A-to-B store register of that lane captures that lane's a_in byte. b_cap_stb does the same for the B-to-A register and b_in. The capture happens whatever the select and enable levels are. A strobe that is held high captures only once.
- R3: With ab_use_store at 0, b_out of the lane equals the a_in byte sampled at the previous clock edge. With ba_use_store at 0, a_out equals the previous b_in byte.
- R4: With ab_use_store at 1, b_out shows the A-to-B store register. With ba_use_store at 1, a_out shows the B-to-A store register. The outputs do not change while no capture occurs.
- R5: ab_drive_en is active high: b_drv equals ab_drive_en sampled at the previous edge.
- R6: ba_drive_en_n is active low: a_drv equals the inverse of ba_drive_en_n sampled at the previous edge.
- R7: With ab_drive_en at 0 and ba_drive_en_n at 1, neither bus is driven, and both store registers still capture on their strobes.
- R8: When only one side is driven and its select is 1, a capture on the opposite bus takes in the stored byte being driven. One value then ends up in both store registers.
- R9: With both selects at 0 and both enables active, each bus keeps its last value after all external drivers are removed.
- R10: Lanes are independent. Lane k uses bits k*LANE_W and up of every data port and bit k of every control and enable port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | LANES*LANE_W | Value seen on the A bus |
| b_in | input | LANES*LANE_W | Value seen on the B bus |
| a_cap_stb | input | LANES | Capture strobe for the A-to-B store register |
| b_cap_stb | input | LANES | Capture strobe for the B-to-A store register |
| ab_use_store | input | LANES | 1: B side gets the stored byte, 0: live A data |
| ba_use_store | input | LANES | 1: A side gets the stored byte, 0: live B data |
| ab_drive_en | input | LANES | Active-high enable for driving the B bus |
| ba_drive_en_n | input | LANES | Active-low enable for driving the A bus |
| a_out | output | LANES*LANE_W | Data offered to the A bus |
| a_drv | output | LANES | A bus drive enable |
| b_out | output | LANES*LANE_W | Data offered to the B bus |
| b_drv | output | LANES | B bus drive enable |

## Verification
A store register that is wrong, or that captured on the wrong edge, shows on the opposite data output one clock after that direction's select goes to 1. A spurious capture while a strobe is held high shows in the same way. A lost or inverted enable shows on a_drv or b_drv at the next clock edge. An output path that does not follow the live input shows one clock later. In the hold-loop case it breaks the kept value within a few cycles after the external drivers are removed. A lane fault shows on the other lane's bytes in the same cycle that it shows on its own lane.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the registered bus transceiver.
// Assumes: lane data width is set by the top-level parameter.
package xcvr_pkg;

    // Per-direction control after enable polarity has been normalised.
    typedef struct packed {
        logic drive;      // 1 = this direction drives its destination bus
        logic use_store;  // 1 = stored byte, 0 = live data
    } dir_ctrl_t;

    // Build a direction control word from the raw active-high enable.
    function automatic dir_ctrl_t make_ctrl(input logic drive_hi, input logic sel);
        dir_ctrl_t c;
        c.drive     = drive_hi;
        c.use_store = sel;
        return c;
    endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
`timescale 1ns/1ps
// Module: xcvr_strobe_edge
// Detects a 0-to-1 change of a synchronous capture strobe.
// Assumes: the strobe is already synchronous to clk. The history bit
// resets to 1, so a strobe held high through reset gives no capture.
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic rise
);

    logic stb_q;

    // Keep the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b1;
        end else begin
            stb_q <= stb;
        end
    end

    assign rise = stb & ~stb_q;

endmodule

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
// Module: xcvr_store_reg
// Store register that loads its data input when load is 1.
// Assumes: load is a single-cycle pulse made by the edge detector.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, capture on a load pulse, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_dir_path.sv
`timescale 1ns/1ps
// Module: xcvr_dir_path
// Registered output stage for one direction. It picks live or stored
// data and registers that byte together with the drive enable.
// Assumes: stored is the store register value before this edge.
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out,
    output logic         drv
);

    logic [W-1:0] pick;

    // Choose the source byte for the destination bus.
    always_comb begin
        pick = ctrl.use_store ? stored : live;
    end

    // Register the byte and the enable. Reset keeps the bus undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= '0;
            drv <= 1'b0;
        end else begin
            out <= pick;
            drv <= ctrl.drive;
        end
    end

endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
// Module: xcvr_lane
// One byte lane: two strobe edge detectors, two store registers and
// two registered output stages, one of each per direction.
// Assumes: the enable for the A-side drive arrives active low.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_cap_stb,
    input  logic         b_cap_stb,
    input  logic         ab_use_store,
    input  logic         ba_use_store,
    input  logic         ab_drive_en,
    input  logic         ba_drive_en_n,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);

    logic         rise_a;
    logic         rise_b;
    logic [W-1:0] store_ab;
    logic [W-1:0] store_ba;
    dir_ctrl_t    ctrl_ab;
    dir_ctrl_t    ctrl_ba;

    // Normalise enable polarity into per-direction control words.
    always_comb begin
        ctrl_ab = make_ctrl(ab_drive_en, ab_use_store);
        ctrl_ba = make_ctrl(~ba_drive_en_n, ba_use_store);
    end

    xcvr_strobe_edge u_edge_a (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (a_cap_stb),
        .rise  (rise_a)
    );

    xcvr_strobe_edge u_edge_b (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (b_cap_stb),
        .rise  (rise_b)
    );

    xcvr_store_reg #(.W(W)) u_store_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rise_a),
        .d     (a_in),
        .q     (store_ab)
    );

    xcvr_store_reg #(.W(W)) u_store_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rise_b),
        .d     (b_in),
        .q     (store_ba)
    );

    xcvr_dir_path #(.W(W)) u_path_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl_ab),
        .live   (a_in),
        .stored (store_ab),
        .out    (b_out),
        .drv    (b_drv)
    );

    xcvr_dir_path #(.W(W)) u_path_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl_ba),
        .live   (b_in),
        .stored (store_ba),
        .out    (a_out),
        .drv    (a_drv)
    );

endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
// Module: bus_xcvr_reg
// Top level: LANES independent byte lanes of the registered transceiver.
// Assumes: all inputs are synchronous to clk. The bus fabric outside
// merges out/drv with the external drivers to form a_in and b_in.
module bus_xcvr_reg #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic [LANES-1:0] a_cap_stb,
    input  logic [LANES-1:0] b_cap_stb,
    input  logic [LANES-1:0] ab_use_store,
    input  logic [LANES-1:0] ba_use_store,
    input  logic [LANES-1:0] ab_drive_en,
    input  logic [LANES-1:0] ba_drive_en_n,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_drv,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_drv
);

    // One lane instance per byte slice.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk           (clk),
            .rst_n         (rst_n),
            .a_in          (a_in[g*LANE_W +: LANE_W]),
            .b_in          (b_in[g*LANE_W +: LANE_W]),
            .a_cap_stb     (a_cap_stb[g]),
            .b_cap_stb     (b_cap_stb[g]),
            .ab_use_store  (ab_use_store[g]),
            .ba_use_store  (ba_use_store[g]),
            .ab_drive_en   (ab_drive_en[g]),
            .ba_drive_en_n (ba_drive_en_n[g]),
            .a_out         (a_out[g*LANE_W +: LANE_W]),
            .a_drv         (a_drv[g]),
            .b_out         (b_out[g*LANE_W +: LANE_W]),
            .b_drv         (b_drv[g])
        );
    end

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
`timescale 1ns/1ps
// Module: bus_xcvr_reg_chk
// Port-level checker for bus_xcvr_reg, attached with bind below.
// Assumes: same parameters as the top level.
module bus_xcvr_reg_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] b_in,
    input logic [LANES-1:0] a_cap_stb,
    input logic [LANES-1:0] b_cap_stb,
    input logic [LANES-1:0] ab_use_store,
    input logic [LANES-1:0] ba_use_store,
    input logic [LANES-1:0] ab_drive_en,
    input logic [LANES-1:0] ba_drive_en_n,
    input logic [BUS_W-1:0] a_out,
    input logic [LANES-1:0] a_drv,
    input logic [BUS_W-1:0] b_out,
    input logic [LANES-1:0] b_drv
);

    // R1: the first edge after reset sees all outputs quiet.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (a_drv == '0 && b_drv == '0 && a_out == '0 && b_out == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R3: live data reaches the opposite side one clock later.
        p_live_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(ab_use_store[g]))
            |-> b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W]));
        p_live_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(ba_use_store[g]))
            |-> a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W]));

        // R4: the stored byte stays put while no capture occurs.
        p_store_hold_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(ab_use_store[g]) &&
             $past(ab_use_store[g], 2) && !$past(a_cap_stb[g], 2))
            |-> $stable(b_out[g*LANE_W +: LANE_W]));
        p_store_hold_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(ba_use_store[g]) &&
             $past(ba_use_store[g], 2) && !$past(b_cap_stb[g], 2))
            |-> $stable(a_out[g*LANE_W +: LANE_W]));

        // R5: active-high enable for driving the B bus.
        p_drv_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> b_drv[g] == $past(ab_drive_en[g]));

        // R6: active-low enable for driving the A bus.
        p_drv_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> a_drv[g] == !$past(ba_drive_en_n[g]));

        // R7: isolation leaves both buses undriven.
        p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(ab_drive_en[g]) && $past(ba_drive_en_n[g]))
            |-> (!a_drv[g] && !b_drv[g]));
    end

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/bus_xcvr_reg_tb.sv
`timescale 1ns/1ps
// Bench for bus_xcvr_reg: a vector table on lane 0, then directed tests.
module bus_xcvr_reg_tb;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int BUS_W  = LANE_W * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BUS_W-1:0] ext_a = '0;
    logic [BUS_W-1:0] ext_b = '0;
    logic [BUS_W-1:0] bus_a;
    logic [BUS_W-1:0] bus_b;
    logic [LANES-1:0] a_cap_stb = '0;
    logic [LANES-1:0] b_cap_stb = '0;
    logic [LANES-1:0] ab_use_store = '1;
    logic [LANES-1:0] ba_use_store = '1;
    logic [LANES-1:0] ab_drive_en = '1;
    logic [LANES-1:0] ba_drive_en_n = '0;
    logic [BUS_W-1:0] a_out;
    logic [BUS_W-1:0] b_out;
    logic [LANES-1:0] a_drv;
    logic [LANES-1:0] b_drv;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    // Bus fabric: the block's byte while it drives, otherwise the external one.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            bus_a[l*LANE_W +: LANE_W] = a_drv[l] ? a_out[l*LANE_W +: LANE_W] : ext_a[l*LANE_W +: LANE_W];
            bus_b[l*LANE_W +: LANE_W] = b_drv[l] ? b_out[l*LANE_W +: LANE_W] : ext_b[l*LANE_W +: LANE_W];
        end
    end

    bus_xcvr_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .a_in          (bus_a),
        .b_in          (bus_b),
        .a_cap_stb     (a_cap_stb),
        .b_cap_stb     (b_cap_stb),
        .ab_use_store  (ab_use_store),
        .ba_use_store  (ba_use_store),
        .ab_drive_en   (ab_drive_en),
        .ba_drive_en_n (ba_drive_en_n),
        .a_out         (a_out),
        .a_drv         (a_drv),
        .b_out         (b_out),
        .b_drv         (b_drv)
    );

    typedef struct packed {
        logic       oe_ab;
        logic       oe_ba_n;
        logic       s_ab;
        logic       s_ba;
        logic       p_ab;
        logic       p_ba;
        logic [7:0] ea;
        logic [7:0] eb;
        logic       x_adrv;
        logic       x_bdrv;
        logic [7:0] x_a;
        logic [7:0] x_b;
    } vec_t;

    // Lane 0 vectors: the expected values are the settled state from R2..R8.
    localparam vec_t TBL [11] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h3C,8'hA5,1'b0,1'b0,8'hA5,8'h3C}, // R7 isolate, capture both
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,8'hA5,8'h3C}, // R4 stored both ways
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h5A,8'hFF,1'b0,1'b1,8'hA5,8'h5A}, // R3 live A to B
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'hC3,1'b1,1'b0,8'hC3,8'h3C}, // R3 live B to A
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h96,8'h11,1'b0,1'b1,8'hA5,8'h96}, // R8 load A reg
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,8'h96,8'h11,1'b0,1'b1,8'h96,8'h96}, // R8 B reg takes driven byte
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,8'hE7,1'b1,1'b0,8'hE7,8'h96}, // R8 load B reg
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'hE7,1'b1,1'b0,8'hE7,8'hE7}, // R8 A reg takes driven byte
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h12,8'h34,1'b0,1'b0,8'hE7,8'hE7}, // R2 no strobe, no capture
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h81,8'h7E,1'b0,1'b0,8'h7E,8'h81}, // R7 capture while live
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,8'h7E,8'h81}  // R4 stored after capture
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Lane 1 is kept in isolation with live selects while lane 0 runs the table.
    task automatic check_lane1(input string req);
        chk(req, {31'd0, a_drv[1]}, 32'd0);
        chk(req, {31'd0, b_drv[1]}, 32'd0);
        chk(req, {24'd0, b_out[15:8]}, 32'hC8);
        chk(req, {24'd0, a_out[15:8]}, 32'h4D);
    endtask

    // Watchdog: an expired run counts as a failure and still ends with the summary.
    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with both enables requested must keep both buses undriven.
        ext_a = 16'hC8_77;
        ext_b = 16'h4D_88;
        cycles(3);
        chk("R1 a_drv in reset", {30'd0, a_drv}, 32'd0);
        chk("R1 b_drv in reset", {30'd0, b_drv}, 32'd0);
        chk("R1 a_out in reset", {16'd0, a_out}, 32'd0);
        chk("R1 b_out in reset", {16'd0, b_out}, 32'd0);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 enables follow first edge", {28'd0, a_drv, b_drv}, 32'hF);
        chk("R1 stored B-to-A cleared", {16'd0, a_out}, 32'd0);
        chk("R1 stored A-to-B cleared", {16'd0, b_out}, 32'd0);

        // Table walk on lane 0; lane 1 held in isolation (R10).
        ab_drive_en[1]   = 1'b0;
        ba_drive_en_n[1] = 1'b1;
        ab_use_store[1]  = 1'b0;
        ba_use_store[1]  = 1'b0;
        foreach (TBL[i]) begin
            ab_drive_en[0]   = TBL[i].oe_ab;
            ba_drive_en_n[0] = TBL[i].oe_ba_n;
            ab_use_store[0]  = TBL[i].s_ab;
            ba_use_store[0]  = TBL[i].s_ba;
            ext_a[7:0]       = TBL[i].ea;
            ext_b[7:0]       = TBL[i].eb;
            cycles(2);
            a_cap_stb[0] = TBL[i].p_ab;
            b_cap_stb[0] = TBL[i].p_ba;
            cycles(1);
            a_cap_stb[0] = 1'b0;
            b_cap_stb[0] = 1'b0;
            cycles(2);
            chk($sformatf("R6 a_drv row %0d", i), {31'd0, a_drv[0]}, {31'd0, TBL[i].x_adrv});
            chk($sformatf("R5 b_drv row %0d", i), {31'd0, b_drv[0]}, {31'd0, TBL[i].x_bdrv});
            chk($sformatf("R2/R3/R4/R8 a_out row %0d", i), {24'd0, a_out[7:0]}, {24'd0, TBL[i].x_a});
            chk($sformatf("R2/R3/R4/R8 b_out row %0d", i), {24'd0, b_out[7:0]}, {24'd0, TBL[i].x_b});
            check_lane1("R10 lane 1 untouched");
        end

        // R2: a strobe held high captures once only.
        ab_drive_en[0]   = 1'b0;
        ba_drive_en_n[0] = 1'b1;
        ab_use_store[0]  = 1'b1;
        ext_a[7:0]       = 8'h11;
        cycles(2);
        a_cap_stb[0] = 1'b1;
        cycles(3);
        ext_a[7:0] = 8'h22;
        cycles(3);
        chk("R2 held strobe keeps first byte", {24'd0, b_out[7:0]}, 32'h11);
        a_cap_stb[0] = 1'b0;
        cycles(2);
        chk("R2 falling strobe no capture", {24'd0, b_out[7:0]}, 32'h11);

        // R9: both live, both driven, external drivers removed.
        ab_use_store[0]  = 1'b0;
        ba_use_store[0]  = 1'b0;
        ab_drive_en[0]   = 1'b1;
        ba_drive_en_n[0] = 1'b1;
        ext_a[7:0]       = 8'h6D;
        cycles(3);
        ba_drive_en_n[0] = 1'b0;
        cycles(3);
        ext_a[7:0] = 8'hFF;
        ext_b[7:0] = 8'h00;
        cycles(5);
        chk("R9 A bus holds", {24'd0, bus_a[7:0]}, 32'h6D);
        chk("R9 B bus holds", {24'd0, bus_b[7:0]}, 32'h6D);

        // R10: lane 1 drives while lane 0 is isolated.
        ab_drive_en   = 2'b10;
        ba_drive_en_n = 2'b11;
        ab_use_store  = 2'b00;
        ext_a         = 16'h5B_24;
        cycles(2);
        chk("R10 drive enables per lane", {30'd0, b_drv}, 32'h2);
        chk("R10 lane 1 live byte", {24'd0, b_out[15:8]}, 32'h5B);
        chk("R10 lane 0 live byte", {24'd0, b_out[7:0]}, 32'h24);

        // R1: a second reset clears both store registers.
        rst_n = 1'b0;
        cycles(2);
        ab_drive_en   = 2'b00;
        ba_drive_en_n = 2'b11;
        ab_use_store  = 2'b11;
        ba_use_store  = 2'b11;
        rst_n = 1'b1;
        cycles(2);
        chk("R1 A-to-B stores cleared", {16'd0, b_out}, 32'd0);
        chk("R1 B-to-A stores cleared", {16'd0, a_out}, 32'd0);
        chk("R7 isolated after reset", {28'd0, a_drv, b_drv}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule